// File: doc/BRIEF.md
# JTAG TAP scan sequencer

This block is a host-side engine that runs scans on a single target test access port. It drives the TMS, TCK and TDI lines and samples TDO. A command chooses one of four operations: a TAP reset, an 8-bit instruction scan, an 8-bit data scan or a 16-bit data scan. The command carries a data word. When the operation has ended, the block returns the word captured from TDO together with a one-cycle done pulse.

Every scan leaves Run-Test/Idle, shifts its bits, and comes back to Idle through Exit, Update and Idle. The TCK low and high phases come from the system clock. Each phase lasts a parameter number of system clocks, which must be at least 2.

The TDI line also works as the target's functional clock while no shift is in progress. The block therefore samples the requested idle level when it accepts a command. It holds that level on TDI outside the shifted bits, and it follows the live request again once the command is done. A TAP reset first toggles TMS while TCK stays high, so that the target can check its security fuse. The reset then clocks the state machine into Test-Logic-Reset and from there to Idle.

Top module: `tap_scan_engine`

## Requirements
- R1: After reset, busy and done are 0, rdata is 0, TCK is 1 and TMS is 0. While not busy, TDI equals idle_tdi.
- R2: Opcode 0 (TAP reset) first holds TCK high while TMS takes the values 0, 1, 0, 1, each held for two half-periods. It then gives six rising TCK edges with TMS at 1, followed by one rising edge with TMS at 0, for 7 rising edges in total.
- R3: Opcode 1 (instruction scan) gives 14 rising TCK edges with TMS values 1, 1, 0, 0, then eight shift edges, then 1, 0. During the shift edges TMS is 0 on all but the last, where it is 1.
- R4: Opcode 2 (8-bit data scan) and opcode 3 (16-bit data scan) give TMS values 1, 0, 0 on three rising edges. They then give 8 or 16 shift edges, with TMS at 1 only on the last, and finish with 1, 0. This makes 13 or 21 rising edges.
- R5: A data scan presents cmd_data[N-1] on TDI at the first shift edge and bit 0 at the last. An instruction scan presents cmd_data[7:0] bit-reversed, so a nominal code of 0x13 appears as 0xC8 when the TDI bits are read most significant first.
- R6: rdata holds the TDO values seen at the shift edges, with the first bit in bit N-1 and the last in bit 0. The upper bits are 0 for 8-bit scans. rdata changes only in the cycle in which done is 1.
- R7: On every non-shift edge of a command, TDI equals the idle_tdi level sampled at accept, even if idle_tdi changes during the command.
- R8: Each TCK level lasts at least HALF_CYC system clocks. done is a single-cycle pulse that rises exactly 2*HALF_CYC*S clocks after the accepting edge, where S is 11, 14, 13 or 21 for opcodes 0 to 3.
- R9: busy rises on the edge that accepts a command and falls with done. A command offered while busy is ignored: it adds no TCK edges and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered; accepted when not busy |
| cmd_op | input | 2 | 0 TAP reset, 1 instruction scan, 2 data scan 8 bits, 3 data scan 16 bits |
| cmd_data | input | 16 | Word to shift out (instruction in its nominal bit order) |
| idle_tdi | input | 1 | Requested TDI/functional-clock level outside the shifted bits |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| rdata | output | 16 | Captured TDO word, right-aligned |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data in / functional clock to the target |
| tdo | input | 1 | Test data out from the target |

## Verification
The done pulse is due exactly 2*HALF_CYC*S clock edges after the accepting edge. The bench counts edges from acceptance and checks this count at the first falling clock edge on which done is seen. rdata and the idle line levels are sampled in that same half cycle. Line values are logged on each rising TCK edge. The toggle phase of a TAP reset is sampled at the half cycle following clock edge 2*HALF_CYC*k+1, which lies inside toggle slot k. The target model changes TDO only on falling TCK, so each shift bit is stable when the engine samples it one system clock after the rising edge.

// File: rtl/tap_scan_pkg.sv
`timescale 1ns/1ps
package tap_scan_pkg;

    localparam int DW          = 16;
    localparam int IR_BITS     = 8;
    localparam int RST_TOGGLES = 4;
    localparam int RST_PULSES  = 6;
    localparam int IR_PRE      = 4;
    localparam int DR_PRE      = 3;
    localparam int POST        = 2;
    localparam int IDX_W       = $clog2(DR_PRE + DW + POST);

    typedef int unsigned uint_t;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_IR    = 2'd1,
        OP_DR8   = 2'd2,
        OP_DR16  = 2'd3
    } scan_op_e;

    // Line values for one TCK slot (one low half plus one high half)
    typedef struct packed {
        logic hold_high;   // TCK stays high for the whole slot
        logic tms;
        logic tdi;
        logic shift;       // TDO is captured in this slot
    } slot_t;

    function automatic uint_t pre_len(scan_op_e op);
        case (op)
            OP_IR:   return uint_t'(IR_PRE);
            OP_RESET: return 0;
            default: return uint_t'(DR_PRE);
        endcase
    endfunction

    function automatic uint_t shift_len(scan_op_e op);
        case (op)
            OP_IR:   return uint_t'(IR_BITS);
            OP_DR8:  return 8;
            OP_DR16: return uint_t'(DW);
            default: return 0;
        endcase
    endfunction

    function automatic uint_t slot_count(scan_op_e op);
        if (op == OP_RESET) return uint_t'(RST_TOGGLES + RST_PULSES + 1);
        return pre_len(op) + shift_len(op) + uint_t'(POST);
    endfunction

    function automatic slot_t slot_info(scan_op_e op, logic [IDX_W-1:0] idx,
                                        logic [DW-1:0] data, logic lvl);
        slot_t s;
        uint_t i, pre, n, k;
        logic [3:0] kb;
        s   = '{hold_high: 1'b0, tms: 1'b0, tdi: lvl, shift: 1'b0};
        i   = uint_t'(idx);
        pre = pre_len(op);
        n   = shift_len(op);
        if (op == OP_RESET) begin
            if (i < uint_t'(RST_TOGGLES)) begin
                s.hold_high = 1'b1;
                s.tms       = idx[0];
            end else begin
                s.tms = (i < uint_t'(RST_TOGGLES + RST_PULSES));
            end
        end else if (i < pre) begin
            s.tms = (i + 2 < pre);
        end else if (i < pre + n) begin
            k       = i - pre;
            s.shift = 1'b1;
            s.tms   = (k == n - 1);
            kb      = (op == OP_IR) ? k[3:0] : 4'(n - 1 - k);
            s.tdi   = data[kb];
        end else begin
            s.tms = (i == pre + n);
        end
        return s;
    endfunction

endpackage

// File: rtl/tap_half_timer.sv
`timescale 1ns/1ps
module tap_half_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic half_end
);
    localparam int CW = $clog2(HALF_CYC) + 1;

    logic [CW-1:0] cnt;

    assign half_end = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || half_end) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tap_slot_seq.sv
`timescale 1ns/1ps
module tap_slot_seq
    import tap_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             half_end,
    input  logic [IDX_W-1:0] last_idx,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             phase,
    output logic             finish,
    output logic             done
);
    assign finish = active && half_end && phase && (idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            phase  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (start) begin
                active <= 1'b1;
                idx    <= '0;
                phase  <= 1'b0;
            end else if (active && half_end) begin
                phase <= ~phase;
                if (phase) begin
                    if (idx == last_idx) active <= 1'b0;
                    else                 idx    <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tap_capture.sv
`timescale 1ns/1ps
module tap_capture
    import tap_scan_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sample_req,
    input  logic          tdo,
    input  logic          finish,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] sh;
    logic          pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            pend  <= 1'b0;
            rdata <= '0;
        end else begin
            pend <= sample_req;
            if (start)     sh <= '0;
            else if (pend) sh <= {sh[DW-2:0], tdo};
            if (finish)    rdata <= sh;
        end
    end
endmodule

// File: rtl/tap_scan_engine.sv
`timescale 1ns/1ps
module tap_scan_engine
    import tap_scan_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    input  logic          idle_tdi,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          tck,
    output logic          tms,
    output logic          tdi,
    input  logic          tdo
);
    scan_op_e         op_q;
    logic [DW-1:0]    data_q;
    logic             lvl_q;
    logic             accept, active, phase, half_end, finish;
    logic [IDX_W-1:0] idx, last_idx;
    slot_t            cur;

    assign accept = cmd_valid && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_RESET;
            data_q <= '0;
            lvl_q  <= 1'b0;
        end else if (accept) begin
            op_q   <= scan_op_e'(cmd_op);
            data_q <= cmd_data;
            lvl_q  <= idle_tdi;
        end
    end

    assign last_idx = IDX_W'(slot_count(op_q) - 1);
    assign cur      = slot_info(op_q, idx, data_q, lvl_q);

    tap_half_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
        .clk(clk), .rst(rst), .run(active), .half_end(half_end)
    );

    tap_slot_seq u_seq (
        .clk(clk), .rst(rst), .start(accept), .half_end(half_end),
        .last_idx(last_idx), .active(active), .idx(idx), .phase(phase),
        .finish(finish), .done(done)
    );

    tap_capture u_cap (
        .clk(clk), .rst(rst), .start(accept),
        .sample_req(active && half_end && !phase && cur.shift),
        .tdo(tdo), .finish(finish), .rdata(rdata)
    );

    assign busy = active;
    assign tck  = !active || cur.hold_high || phase;
    assign tms  = active && cur.tms;
    assign tdi  = active ? cur.tdi : idle_tdi;
endmodule

// File: rtl/tap_scan_chk.sv
`timescale 1ns/1ps
module tap_scan_chk #(
    parameter int HALF_CYC = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        idle_tdi,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        tck,
    input logic        tms,
    input logic        tdi
);
    localparam int RW = $clog2(HALF_CYC) + 2;

    logic          tck_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tck_q <= 1'b1;
            run_q <= RW'(HALF_CYC);
        end else begin
            tck_q <= tck;
            if (tck != tck_q)              run_q <= RW'(1);
            else if (run_q != {RW{1'b1}})  run_q <= run_q + 1'b1;
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R8
    tck_half_chk: assert property (@(posedge clk) disable iff (rst)
        (tck != tck_q) |-> (run_q >= RW'(HALF_CYC)));
    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(cmd_valid));
    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tck && !tms && (tdi == idle_tdi)));
    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(rdata));
endmodule

bind tap_scan_engine tap_scan_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .idle_tdi(idle_tdi),
    .busy(busy), .done(done), .rdata(rdata), .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/sim_tap_scan_engine.sv
`timescale 1ns/1ps
module sim_tap_scan_engine;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_data = '0;
    logic        idle_tdi = 1'b1;
    logic        busy, done, tck, tms, tdi, tdo;
    logic [15:0] rdata;

    int chk = 0;
    int bad = 0;
    bit fin = 0;

    always #10 clk = ~clk;

    tap_scan_engine #(.HALF_CYC(H)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .idle_tdi(idle_tdi), .busy(busy), .done(done),
        .rdata(rdata), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    // Target model: TDO changes only on falling TCK
    logic [31:0] pat = 32'hA5C3_1E97;
    assign tdo = pat[31];
    always @(negedge tck) pat <= {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]};

    // Log of the lines at each rising TCK
    bit   log_en = 0;
    int   nlog = 0;
    logic tms_log [0:31];
    logic tdi_log [0:31];
    logic tdo_log [0:31];
    always @(posedge tck) if (log_en && nlog < 32) begin
        tms_log[nlog] = tms;
        tdi_log[nlog] = tdi;
        tdo_log[nlog] = tdo;
        nlog++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        chk++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int slots_of(input int op);
        case (op) 0: return 11; 1: return 14; 2: return 13; default: return 21; endcase
    endfunction
    function automatic int edges_of(input int op);
        return (op == 0) ? 7 : slots_of(op);
    endfunction
    function automatic int pre_of(input int op);
        return (op == 1) ? 4 : 3;
    endfunction
    function automatic int bits_of(input int op);
        return (op == 3) ? 16 : 8;
    endfunction
    function automatic logic exp_tms(input int op, input int e);
        int p, n;
        if (op == 0) return (e != 6);
        p = pre_of(op); n = bits_of(op);
        if (e < p)      return (op == 1) ? (e < 2) : (e == 0);
        if (e < p + n)  return (e == p + n - 1);
        return (e == p + n);
    endfunction
    function automatic logic exp_tdi(input int op, input logic [15:0] d, input logic lvl, input int e);
        int p, n;
        if (op == 0) return lvl;
        p = pre_of(op); n = bits_of(op);
        if (e >= p && e < p + n) return (op == 1) ? d[e - p] : d[n - 1 - (e - p)];
        return lvl;
    endfunction

    task automatic run_scan(input int op, input logic [15:0] d, input logic lvl,
                            input bit flip_lvl, input bit junk);
        int c;
        logic smp_tck [0:127];
        logic smp_tms [0:127];
        logic [15:0] exp_rd;
        logic [7:0]  irb;
        int p, n;
        @(negedge clk);
        idle_tdi = lvl;
        nlog = 0; log_en = 1;
        cmd_valid = 1; cmd_op = op[1:0]; cmd_data = d;
        @(posedge clk);
        c = 0;
        forever begin
            @(negedge clk);
            if (c < 128) begin smp_tck[c] = tck; smp_tms[c] = tms; end
            if (c == 0) begin
                check(busy == 1'b1, "R9 busy after accept", busy, 1);
                if (junk) begin cmd_valid = 1; cmd_op = 2'd3; cmd_data = ~d; end
                else cmd_valid = 0;
                if (flip_lvl) idle_tdi = ~lvl;
            end else cmd_valid = 0;
            if (done || c > 2000) break;
            @(posedge clk);
            c++;
        end
        log_en = 0;
        check(c == 2 * H * slots_of(op), "R8 done latency", c, 2 * H * slots_of(op));
        check(busy == 1'b0, "R9 busy cleared with done", busy, 0);
        check(nlog == edges_of(op), "R9/R2/R3/R4 rising TCK count", nlog, edges_of(op));
        for (int e = 0; e < edges_of(op) && e < nlog; e++) begin
            check(tms_log[e] == exp_tms(op, e), $sformatf("R2/R3/R4 tms at edge %0d op %0d", e, op),
                  tms_log[e], exp_tms(op, e));
            check(tdi_log[e] == exp_tdi(op, d, lvl, e), $sformatf("R5/R7 tdi at edge %0d op %0d", e, op),
                  tdi_log[e], exp_tdi(op, d, lvl, e));
        end
        if (op == 0) begin
            for (int k = 0; k < 4; k++) begin
                check(smp_tck[2*H*k+1] == 1'b1, "R2 tck high during toggle", smp_tck[2*H*k+1], 1);
                check(smp_tms[2*H*k+1] == k[0], "R2 tms toggle pattern", smp_tms[2*H*k+1], k[0]);
            end
            check(smp_tck[8*H+1] == 1'b0, "R2 first reset pulse low", smp_tck[8*H+1], 0);
            check(rdata == 16'h0, "R6 reset rdata", rdata, 0);
        end else begin
            p = pre_of(op); n = bits_of(op);
            exp_rd = '0;
            for (int k = 0; k < n; k++) exp_rd = {exp_rd[14:0], tdo_log[p + k]};
            check(rdata == exp_rd, "R6 captured word", rdata, exp_rd);
            if (op == 1) begin
                irb = '0;
                for (int k = 0; k < 8; k++) irb = {irb[6:0], tdi_log[p + k]};
                check(irb == {d[0], d[1], d[2], d[3], d[4], d[5], d[6], d[7]},
                      "R5 instruction bit reversal", irb, {d[0], d[1], d[2], d[3], d[4], d[5], d[6], d[7]});
            end
        end
        check(tdi == idle_tdi && tck && !tms, "R7/R1 idle lines after done",
              {tck, tms, tdi}, {1'b1, 1'b0, idle_tdi});
    endtask

    initial begin
        #(20 * 200000);
        if (!fin) begin
            bad++;
            chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_0427));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(!busy && !done && rdata == 0, "R1 reset state", {busy, done}, 0);
        check(tck && !tms && tdi == idle_tdi, "R1 reset lines", {tck, tms, tdi}, {2'b10, idle_tdi});
        // Directed cases
        run_scan(0, 16'h0000, 1'b1, 1'b0, 1'b0);
        run_scan(1, 16'h0013, 1'b1, 1'b0, 1'b0);
        run_scan(1, 16'h0013, 1'b0, 1'b1, 1'b1);
        run_scan(3, 16'h2401, 1'b1, 1'b1, 1'b0);
        run_scan(2, 16'h00A5, 1'b0, 1'b0, 1'b1);
        run_scan(3, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        run_scan(0, 16'hFFFF, 1'b0, 1'b1, 1'b1);
        // Random mix
        for (int t = 0; t < 40; t++) begin
            r = $urandom;
            run_scan(int'(r[1:0]), 16'($urandom), r[2], r[3], r[4]);
        end
        fin = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk, bad);
        $finish;
    end
endmodule